// File: doc/BRIEF.md
# Byte-Level I2C Master Engine

This block is an I2C bus master that software steps one byte at a time through four byte-wide registers. Software loads the address or data byte, then starts a transfer with a write to the status register. The engine sends a START and shifts the byte out. It samples the acknowledge slot, sets a pending flag and keeps SCL low. Nothing further happens on the bus until software clears the pending flag. What happens next depends on what software has asked for since the flag was set: the next byte in the current direction, a repeated START, or a STOP.

The SCL rate comes from a two-way prescale (16 or 512 input clocks) followed by a 4-bit divisor. SCL and SDA are open-drain. Each line appears as an output enable that pulls the wire low, plus an input that reads the resolved wire. A bus monitor watches the wires for START and STOP conditions and reports whether the bus is busy. An interrupt output follows the pending flag when interrupts are enabled.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset all four registers read 0x00, scl_oe and sda_oe are 0 and irq is 0.
- R2: Register addresses are 0 control, 1 status, 2 own address, 3 data. The own-address register keeps 7 bits and bit 7 reads 0. A status write stores the mode in bits [7:6] and the output enable in bit 4. Writing 0x00 to status reads back 0x00 while the bus is free.
- R3: During a byte, the SCL period in input clocks is P×(D+1). P is 512 when control bit 6 is 1 and 16 when it is 0. D is control bits [3:0].
- R4: A status write with bits 7, 5 and 4 all set, while the engine is idle and the bus is free, drives a START and then sends the data register MSB first. Within a byte, SDA changes only while SCL is driven low.
- R5: When a byte's ninth clock pulse ends, control bit 4 (pending) is set and SCL is held low. A control write with bit 4 = 0 clears the flag and releases the bus. Writing bit 4 = 1 neither sets the flag nor releases SCL.
- R6: Status bit 0 holds the SDA level sampled in the acknowledge slot of the last transmitted byte. A 1 means NACK.
- R7: In mode 2'b10, bytes after the address byte are received MSB first into the data register. The master pulls the acknowledge slot low only when control bit 7 is 1, and leaves it released (NACK) otherwise.
- R8: A status write with bit 5 = 0, made in a master mode while pending, followed by clearing pending, produces a STOP. Afterwards status bit 5 reads 0 and both lines are released.
- R9: A status write with bits 7, 5 and 4 set while pending, followed by clearing pending, produces a repeated START followed by the data register byte.
- R10: Status bit 5 reads the bus-busy state. It is set when SDA falls while SCL is high and cleared when SDA rises while SCL is high.
- R11: irq equals control bit 4 AND control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Resolved SCL wire level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA wire level |

## Verification
The assertions check on every cycle that SCL stays low whenever the pending flag is set. They also check that the flag only rises at the end of a byte, that SDA holds steady while SCL is released inside a byte, and that the bus monitor reports busy whenever a byte is on the wire. The bench's scenarios cover what the assertions cannot see. These include the measured SCL period for three prescale and divisor settings and the exact bytes a modelled target receives and returns. They also show the ACK and NACK levels the target observes from the master, the NACK reported for an absent address, and the repeated START and STOP sequences driven by software.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
    localparam int BYTE_W  = 8;
    localparam int DIV_W   = 4;
    localparam int BIT_CW  = $clog2(BYTE_W + 1);

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_OWN  = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    // control field positions
    localparam int CT_PEND = 4;
    localparam int CT_IE   = 5;
    localparam int CT_PRE  = 6;
    localparam int CT_ACK  = 7;
    // status field positions
    localparam int SR_NACK = 0;
    localparam int SR_TXEN = 4;
    localparam int SR_BUSY = 5;

    typedef enum logic [2:0] {E_IDLE, E_START, E_BITS, E_HOLD, E_STOP} eng_t;

    typedef struct packed {
        eng_t              st;
        logic [1:0]        ph;
        logic [BIT_CW-1:0] bitn;
        logic              rx;
        logic [BYTE_W-1:0] ctrl;
        logic [1:0]        mode;
        logic              txen;
        logic              nack;
        logic [BYTE_W-2:0] own;
        logic [BYTE_W-1:0] data;
        logic              scl_oe;
        logic              sda_oe;
        logic              stop_req;
        logic              rs_req;
    } core_t;
endpackage

// File: rtl/i2cm_tick.sv
`timescale 1ns/1ps
module i2cm_tick #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sel_hi,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    // one tick per quarter of an SCL period
    localparam int Q_LO = PRE_LO / 4;
    localparam int Q_HI = PRE_HI / 4;
    localparam int CW   = $clog2(Q_HI);

    typedef struct packed {
        logic [CW-1:0]    pre;
        logic [DIV_W-1:0] dv;
        logic             tick;
    } tk_t;

    tk_t q, d;
    logic [CW-1:0] pre_lim;

    always_comb begin
        pre_lim = sel_hi ? CW'(Q_HI - 1) : CW'(Q_LO - 1);
        d       = q;
        d.tick  = 1'b0;
        if (!en) begin
            d.pre = '0;
            d.dv  = '0;
        end else if (q.pre < pre_lim) begin
            d.pre = q.pre + 1'b1;
        end else begin
            d.pre = '0;
            if (q.dv < div) begin
                d.dv = q.dv + 1'b1;
            end else begin
                d.dv   = '0;
                d.tick = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/i2cm_bus_watch.sv
`timescale 1ns/1ps
module i2cm_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic busy;
    } bw_t;

    bw_t q, d;

    always_comb begin
        d       = q;
        d.scl_p = scl_in;
        d.sda_p = sda_in;
        if (q.scl_p && scl_in && q.sda_p && !sda_in)      d.busy = 1'b1;
        else if (q.scl_p && scl_in && !q.sda_p && sda_in) d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{scl_p: 1'b1, sda_p: 1'b1, busy: 1'b0};
        else        q <= d;
    end

    assign busy = q.busy;
endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    output logic              scl_oe,
    input  logic              scl_in,
    output logic              sda_oe,
    input  logic              sda_in
);
    core_t q, d;
    logic  tick, busy, run;
    logic  wr_ctl, wr_sta, wr_own, wr_dat;

    assign run = (q.st == E_START) || (q.st == E_BITS) || (q.st == E_STOP);

    i2cm_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(run), .sel_hi(q.ctrl[CT_PRE]),
        .div(q.ctrl[DIV_W-1:0]), .tick(tick)
    );

    i2cm_bus_watch u_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .busy(busy)
    );

    // value for the SDA pull-down in the bit slot described by s
    function automatic logic drive_bit(input core_t s);
        if (s.bitn == BIT_CW'(BYTE_W)) return s.rx ? s.ctrl[CT_ACK] : 1'b0;
        return s.rx ? 1'b0 : ~s.data[BYTE_W-1];
    endfunction

    always_comb begin
        d      = q;
        wr_ctl = reg_wr && (reg_addr == A_CTRL);
        wr_sta = reg_wr && (reg_addr == A_STAT);
        wr_own = reg_wr && (reg_addr == A_OWN);
        wr_dat = reg_wr && (reg_addr == A_DATA);

        if (wr_own) d.own  = reg_wdata[BYTE_W-2:0];
        if (wr_dat) d.data = reg_wdata;

        if (wr_sta) begin
            d.mode = reg_wdata[7:6];
            d.txen = reg_wdata[SR_TXEN];
            if (reg_wdata[SR_BUSY] && reg_wdata[7] && reg_wdata[SR_TXEN]) begin
                if (q.st == E_IDLE && !busy) begin
                    d.st     = E_START;
                    d.ph     = 2'd0;
                    d.scl_oe = 1'b1;
                    d.sda_oe = 1'b0;
                end else if (q.st == E_HOLD) begin
                    d.rs_req = 1'b1;
                end
            end else if (!reg_wdata[SR_BUSY] && q.mode[1] && q.st == E_HOLD) begin
                d.stop_req = 1'b1;
            end
        end

        if (wr_ctl) begin
            d.ctrl          = reg_wdata;
            d.ctrl[CT_PEND] = q.ctrl[CT_PEND] & reg_wdata[CT_PEND];
            if (q.st == E_HOLD && q.ctrl[CT_PEND] && !reg_wdata[CT_PEND]) begin
                d.stop_req = 1'b0;
                d.rs_req   = 1'b0;
                d.ph       = 2'd0;
                d.scl_oe   = 1'b1;
                if (q.stop_req) begin
                    d.st     = E_STOP;
                    d.sda_oe = 1'b1;
                end else if (q.rs_req) begin
                    d.st     = E_START;
                    d.sda_oe = 1'b0;
                end else begin
                    d.st     = E_BITS;
                    d.bitn   = '0;
                    d.rx     = (q.mode == 2'b10);
                    d.sda_oe = drive_bit(d);
                end
            end
        end

        if (tick) begin
            case (q.st)
                E_START: begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: d.scl_oe = 1'b0;
                        2'd1: d.sda_oe = 1'b1;
                        2'd2: d.scl_oe = 1'b1;
                        default: begin
                            d.st     = E_BITS;
                            d.ph     = 2'd0;
                            d.bitn   = '0;
                            d.rx     = 1'b0;
                            d.sda_oe = drive_bit(d);
                        end
                    endcase
                end
                E_BITS: begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd1: begin
                            d.scl_oe = 1'b0;
                            if (q.bitn < BIT_CW'(BYTE_W)) d.data = {q.data[BYTE_W-2:0], sda_in};
                            else if (!q.rx)               d.nack = sda_in;
                        end
                        2'd3: begin
                            d.scl_oe = 1'b1;
                            d.ph     = 2'd0;
                            if (q.bitn == BIT_CW'(BYTE_W)) begin
                                d.st            = E_HOLD;
                                d.sda_oe        = 1'b0;
                                d.ctrl[CT_PEND] = 1'b1;
                            end else begin
                                d.bitn   = q.bitn + 1'b1;
                                d.sda_oe = drive_bit(d);
                            end
                        end
                        default: ;
                    endcase
                end
                E_STOP: begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: d.scl_oe = 1'b0;
                        2'd1: d.sda_oe = 1'b0;
                        default: begin
                            d.st = E_IDLE;
                            d.ph = 2'd0;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = q.ctrl;
            A_STAT:  reg_rdata = {q.mode, busy, q.txen, 3'b000, q.nack};
            A_OWN:   reg_rdata = {1'b0, q.own};
            default: reg_rdata = q.data;
        endcase
    end

    assign scl_oe = q.scl_oe;
    assign sda_oe = q.sda_oe;
    assign irq    = q.ctrl[CT_PEND] & q.ctrl[CT_IE];

    AST_SCL_LOW_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        q.ctrl[CT_PEND] |-> q.scl_oe); // R5
    AST_PEND_RISES_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ctrl[CT_PEND]) |-> ($past(q.st) == E_BITS)); // R5
    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == E_BITS && $past(q.st) == E_BITS && !q.scl_oe) |-> $stable(q.sda_oe)); // R4
    AST_BUSY_DURING_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == E_BITS) |-> busy); // R10
endmodule

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       sl_sda = 1'b0;
    logic       scl_w, sda_w;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    assign scl_w = ~scl_oe;
    assign sda_w = ~(sda_oe | sl_sda);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .scl_in(scl_w), .sda_oe(sda_oe), .sda_in(sda_w)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_pend(input string tag);
        logic [7:0] v;
        int k;
        k = 0;
        do begin rd(2'd0, v); k++; end while (!v[4] && k < 20000);
        chk(tag, {31'd0, v[4]}, 1);
    endtask

    task automatic wait_free(input string tag);
        logic [7:0] v;
        int k;
        k = 0;
        do begin rd(2'd1, v); k++; end while (v[5] && k < 20000);
        chk(tag, {31'd0, v[5]}, 0);
        chk({tag, " lines released"}, {30'd0, scl_oe, sda_oe}, 0);
        repeat (600) @(negedge clk);
    endtask

    // target model, one byte at a time
    task automatic sl_wait_start();
        do @(negedge sda_w); while (scl_w !== 1'b1);
    endtask

    task automatic sl_rx_byte(output logic [7:0] b, input logic ack);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_w);
            b = {b[6:0], sda_w};
        end
        @(negedge scl_w);
        sl_sda = ack;
        @(negedge scl_w);
        sl_sda = 1'b0;
    endtask

    task automatic sl_tx_byte(input logic [7:0] b, output logic m);
        for (int i = 7; i >= 0; i--) begin
            sl_sda = ~b[i];
            @(negedge scl_w);
        end
        sl_sda = 1'b0;
        @(posedge scl_w);
        m = sda_w;
        @(negedge scl_w);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset value", {24'd0, v}, 0);
        end
        chk("R1 lines and irq after reset", {29'd0, scl_oe, sda_oe, irq}, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd2, 8'hFF); rd(2'd2, v);
        chk("R2 own address keeps 7 bits", {24'd0, v}, 8'h7F);
        wr(2'd0, 8'h1F); rd(2'd0, v);
        chk("R5 writing pending as 1 does not set it", {24'd0, v}, 8'h0F);
        wr(2'd1, 8'hD0); rd(2'd1, v);
        chk("R2 status mode and enable stored", {24'd0, v}, 8'hD0);
        wr(2'd1, 8'h00); rd(2'd1, v);
        chk("R2 status write of zero", {24'd0, v}, 8'h00);
        wr(2'd3, 8'h5A); rd(2'd3, v);
        chk("R2 data register", {24'd0, v}, 8'h5A);
    endtask

    task automatic t_write();
        logic [7:0] a, b1, b2, v;
        wr(2'd0, 8'hA0);
        fork
            begin
                sl_wait_start();
                sl_rx_byte(a, 1'b1);
                sl_rx_byte(b1, 1'b1);
                sl_rx_byte(b2, 1'b1);
            end
            begin
                wr(2'd3, 8'hA0);
                wr(2'd1, 8'hF0);
                wait_pend("R5 pending after address byte");
                rd(2'd1, v);
                chk("R6 ACK seen after address", {31'd0, v[0]}, 0);
                chk("R10 busy after START", {31'd0, v[5]}, 1);
                chk("R11 irq with enable set", {31'd0, irq}, 1);
                repeat (300) @(negedge clk);
                chk("R5 SCL held low while pending", {31'd0, scl_oe}, 1);
                wr(2'd0, 8'hB0);
                repeat (100) @(negedge clk);
                rd(2'd0, v);
                chk("R5 writing 1 keeps pending", {31'd0, v[4]}, 1);
                chk("R5 writing 1 keeps SCL low", {31'd0, scl_oe}, 1);
                wr(2'd3, 8'h3C); wr(2'd0, 8'hA0);
                wait_pend("R5 pending after first data byte");
                wr(2'd3, 8'hC5); wr(2'd0, 8'hA0);
                wait_pend("R5 pending after second data byte");
                rd(2'd1, v);
                chk("R6 ACK seen after data", {31'd0, v[0]}, 0);
                wr(2'd1, 8'hD0); wr(2'd0, 8'hA0);
                wait_free("R8 STOP clears busy");
            end
        join
        chk("R4 address byte on the wire", {24'd0, a}, 8'hA0);
        chk("R4 first data byte", {24'd0, b1}, 8'h3C);
        chk("R4 second data byte", {24'd0, b2}, 8'hC5);
    endtask

    task automatic t_nack();
        logic [7:0] v;
        wr(2'd0, 8'h80);
        wr(2'd3, 8'hB0);
        wr(2'd1, 8'hF0);
        wait_pend("R5 pending with absent target");
        rd(2'd1, v);
        chk("R6 NACK reported", {31'd0, v[0]}, 1);
        chk("R11 irq low with enable clear", {31'd0, irq}, 0);
        wr(2'd1, 8'hD0); wr(2'd0, 8'h80);
        wait_free("R8 STOP after NACK");
    endtask

    task automatic t_rate(input logic pre, input logic [3:0] dv, input int exp);
        int c0, c1;
        wr(2'd0, {1'b1, pre, 2'b00, dv});
        wr(2'd3, 8'hB0);
        wr(2'd1, 8'hF0);
        @(posedge scl_w);
        @(posedge scl_w); c0 = cyc;
        @(posedge scl_w); c1 = cyc;
        chk("R3 SCL period in clocks", c1 - c0, exp);
        wait_pend("R5 pending in rate test");
        wr(2'd1, 8'hD0); wr(2'd0, {1'b1, pre, 2'b00, dv});
        wait_free("R8 STOP in rate test");
    endtask

    task automatic t_read();
        logic [7:0] a1, r, a2, v;
        logic m1, m2;
        wr(2'd0, 8'hA0);
        fork
            begin
                sl_wait_start();
                sl_rx_byte(a1, 1'b1);
                sl_rx_byte(r, 1'b1);
                sl_wait_start();
                sl_rx_byte(a2, 1'b1);
                sl_tx_byte(8'h96, m1);
                sl_tx_byte(8'h4B, m2);
            end
            begin
                wr(2'd3, 8'hA0); wr(2'd1, 8'hF0);
                wait_pend("R5 pending after write address");
                wr(2'd3, 8'h05); wr(2'd0, 8'hA0);
                wait_pend("R5 pending after index byte");
                wr(2'd3, 8'hA1); wr(2'd1, 8'hB0); wr(2'd0, 8'hA0);
                wait_pend("R9 pending after repeated START address");
                rd(2'd1, v);
                chk("R9 ACK after repeated START address", {31'd0, v[0]}, 0);
                wr(2'd0, 8'hA0);
                wait_pend("R7 pending after first read byte");
                rd(2'd3, v);
                chk("R7 first received byte", {24'd0, v}, 8'h96);
                wr(2'd0, 8'h20);
                wait_pend("R7 pending after last read byte");
                rd(2'd3, v);
                chk("R7 last received byte", {24'd0, v}, 8'h4B);
                wr(2'd1, 8'h90); wr(2'd0, 8'h20);
                wait_free("R8 STOP after read");
            end
        join
        chk("R4 write address before restart", {24'd0, a1}, 8'hA0);
        chk("R4 index byte", {24'd0, r}, 8'h05);
        chk("R9 address after repeated START", {24'd0, a2}, 8'hA1);
        chk("R7 master ACK with ack enable", {31'd0, m1}, 0);
        chk("R7 master NACK with ack disabled", {31'd0, m2}, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_write();
        t_nack();
        t_rate(1'b0, 4'd0, 16);
        t_rate(1'b0, 4'd2, 48);
        t_rate(1'b1, 4'd0, 512);
        t_read();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule